// File: doc/BRIEF.md
# Dual-Plane Packet Path Selector

This block sits between two redundant switch planes, X and Y, and a single transmit output. Each plane has its own transmit FIFO. Switch control drives two in-service status lines, and the selector uses them to pick the plane whose FIFO feeds the output. It tells the upstream extraction stages which FIFO may be written through a one-hot write-enable mask. It drives a stop control to every FIFO that is not selected, and it pops words only from the selected FIFO.

Packets have a fixed length of `PKT_WORDS` words (default 20 words of 32 bits). A word counter tracks the position inside the current packet. A plane change that switch control asks for while a packet is in flight is held back. It takes effect in the cycle after the last word of that packet is forwarded. When no packet is in flight, the change takes effect on the next clock edge. Packets may be duplicated or lost around a switchover, and the block makes no attempt to repair this.

Top module: `dps_path_select`

## Requirements
- R1: During and directly after reset, no plane is selected: `wr_mask` = 2'b00, `stop_mask` = 2'b11, `x_rd` = `y_rd` = 0 and `out_valid` = 0.
- R2: When only `x_in_svc` is high, plane X is selected at the next packet boundary: `wr_mask` = 2'b01 (bit 0 = X) and `stop_mask` = 2'b10.
- R3: When only `y_in_svc` is high, plane Y is selected at the next packet boundary: `wr_mask` = 2'b10 (bit 1 = Y) and `stop_mask` = 2'b01.
- R4: When both in-service inputs are high, the current plane is kept. If no plane is selected at that point, X is chosen.
- R5: When neither in-service input is high, the block goes idle at the next packet boundary: `wr_mask` = 2'b00, `stop_mask` = 2'b11, and no word is read or forwarded.
- R6: A word is forwarded in each cycle in which the selected FIFO shows valid, and a packet is `PKT_WORDS` such words. While a packet is partly forwarded (1 to `PKT_WORDS`-1 words done), the selection does not change. A pending change takes effect in the cycle after the packet's last word is forwarded. When no packet is in progress, a change takes effect in the cycle after the inputs ask for it.
- R7: `wr_mask` has at most one bit set, and `stop_mask` is always its bitwise complement.
- R8: Each word read from the selected FIFO appears on `out_data` with `out_valid` high exactly one cycle later, in read order. `out_valid` is low in every other cycle.
- R9: The FIFO that is not selected is never read: `x_rd` = `x_valid` when X is selected, `y_rd` = `y_valid` when Y is selected, and both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in_svc | input | 1 | Plane X in-service status from switch control |
| y_in_svc | input | 1 | Plane Y in-service status from switch control |
| x_valid | input | 1 | Plane X transmit FIFO holds a word |
| x_data | input | DATA_W | Plane X transmit FIFO head word |
| y_valid | input | 1 | Plane Y transmit FIFO holds a word |
| y_data | input | DATA_W | Plane Y transmit FIFO head word |
| x_rd | output | 1 | Pop plane X FIFO |
| y_rd | output | 1 | Pop plane Y FIFO |
| wr_mask | output | 2 | Write enable to upstream stages, bit 0 = X, bit 1 = Y |
| stop_mask | output | 2 | Stop control per FIFO, bit 0 = X, bit 1 = Y |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output word |

## Verification
The hardest case to reach from the ports is a switchover request that arrives partway through a packet while the FIFO valid has gaps. In that case the boundary falls on a cycle that depends on the whole history of valid cycles. The stimulus drops one in-service line in the middle of a packet and uses irregular valid patterns. A behavioural model counts the accepted words and predicts the exact cycle of the switch, and the bench compares the masks, the pops and the output against it on every clock. A further sequence moves the inputs through both-high, neither-high and back to both-high, so that the keep-current rule is checked both from a selected plane and from idle.

// File: rtl/dps_pkg.sv
package dps_pkg;
   // Plane selection encoding; the value doubles as the write-enable mask
   typedef enum logic [1:0] {
      PL_NONE = 2'b00,
      PL_X    = 2'b01,
      PL_Y    = 2'b10
   } plane_e;
endpackage

// File: rtl/dps_plane_arbiter.sv
module dps_plane_arbiter
   import dps_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   x_svc,
   input  logic   y_svc,
   input  logic   boundary,
   output plane_e sel
);
   plane_e req;

   always_comb begin
      if (x_svc && y_svc) begin
         req = (sel == PL_NONE) ? PL_X : sel;
      end else if (x_svc) begin
         req = PL_X;
      end else if (y_svc) begin
         req = PL_Y;
      end else begin
         req = PL_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= PL_NONE;
      end else if (boundary) begin
         sel <= req;
      end
   end

   // R4
   both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && x_svc && y_svc && sel != PL_NONE) |=> $stable(sel));
endmodule

// File: rtl/dps_word_counter.sv
module dps_word_counter #(
   parameter int PKT_WORDS = 20,
   localparam int CNT_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   output logic [CNT_W-1:0] cnt,
   output logic             boundary
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_WORDS - 1);

   logic at_last;
   assign at_last  = (cnt == LAST);
   assign boundary = (cnt == '0 && !fire) || (at_last && fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (fire) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
      end
   end

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && at_last) |=> (cnt == '0));
   // R6
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/dps_out_stage.sv
module dps_out_stage #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_data  <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_data <= in_data;
               end
            end
         end
         // R8
         out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && out_data == $past(in_data)));
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_data  = in_valid ? in_data : '0;
      end
   endgenerate
endmodule

// File: rtl/dps_path_select.sv
module dps_path_select
   import dps_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PKT_WORDS = 20,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              x_in_svc,
   input  logic              y_in_svc,
   input  logic              x_valid,
   input  logic [DATA_W-1:0] x_data,
   input  logic              y_valid,
   input  logic [DATA_W-1:0] y_data,
   output logic              x_rd,
   output logic              y_rd,
   output logic [1:0]        wr_mask,
   output logic [1:0]        stop_mask,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int CNT_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

   generate
      if (PKT_WORDS < 2) begin : g_bad_pkt
         $error("dps_path_select: PKT_WORDS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dps_path_select: DATA_W must be positive");
      end
   endgenerate

   plane_e            sel;
   logic              fire;
   logic              boundary;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] mux_data;

   assign x_rd      = (sel == PL_X) && x_valid;
   assign y_rd      = (sel == PL_Y) && y_valid;
   assign fire      = x_rd || y_rd;
   assign mux_data  = (sel == PL_Y) ? y_data : x_data;
   assign wr_mask   = sel;
   assign stop_mask = ~sel;

   dps_plane_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .x_svc    (x_in_svc),
      .y_svc    (y_in_svc),
      .boundary (boundary),
      .sel      (sel)
   );

   dps_word_counter #(.PKT_WORDS(PKT_WORDS)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .cnt      (cnt),
      .boundary (boundary)
   );

   dps_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (fire),
      .in_data   (mux_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R7
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_mask));
   // R7
   stop_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mask ^ wr_mask) == 2'b11);
   // R9
   single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(x_rd && y_rd));
   // R6
   no_midpkt_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !(fire && cnt == CNT_W'(PKT_WORDS - 1))) |=> $stable(wr_mask));
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask == 2'b00) |-> (!x_rd && !y_rd));
endmodule

// File: tb/tb_dps_path_select.sv
module tb_dps_path_select;
   localparam int CLK_PERIOD = 10;
   localparam int PKT        = 20;
   localparam int DW         = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          x_in_svc = 1'b0, y_in_svc = 1'b0;
   logic          x_valid = 1'b0, y_valid = 1'b0;
   logic [DW-1:0] x_data = '0, y_data = '0;
   logic          x_rd, y_rd, out_valid;
   logic [1:0]    wr_mask, stop_mask;
   logic [DW-1:0] out_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   dps_path_select #(.DATA_W(DW), .PKT_WORDS(PKT), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .x_in_svc(x_in_svc), .y_in_svc(y_in_svc),
      .x_valid(x_valid), .x_data(x_data),
      .y_valid(y_valid), .y_data(y_data),
      .x_rd(x_rd), .y_rd(y_rd),
      .wr_mask(wr_mask), .stop_mask(stop_mask),
      .out_valid(out_valid), .out_data(out_data)
   );

   // Behavioural reference: 0 = none, 1 = X, 2 = Y
   int            msel = 0;
   int            mcnt = 0;
   bit            mov  = 1'b0;
   logic [DW-1:0] mod  = '0;
   int            checks = 0;
   int            fails  = 0;
   int            seq    = 0;
   bit            done   = 1'b0;

   always @(posedge clk) begin
      int  req;
      bit  fire;
      bit  bnd;
      if (!rst_n) begin
         msel = 0; mcnt = 0; mov = 1'b0; mod = '0;
      end else begin
         if (x_in_svc && y_in_svc) req = (msel == 0) ? 1 : msel;
         else if (x_in_svc)        req = 1;
         else if (y_in_svc)        req = 2;
         else                      req = 0;
         fire = (msel == 1 && x_valid) || (msel == 2 && y_valid);
         bnd  = (mcnt == 0 && !fire) || (mcnt == PKT-1 && fire);
         mov  = fire;
         if (fire) mod = (msel == 1) ? x_data : y_data;
         if (fire) mcnt = (mcnt == PKT-1) ? 0 : mcnt + 1;
         if (bnd) msel = req;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [1:0] em;
      logic [1:0] er;
      string      tag;
      em = (msel == 1) ? 2'b01 : (msel == 2) ? 2'b10 : 2'b00;
      er = {(msel == 2) && y_valid, (msel == 1) && x_valid};
      if (!rst_n)                     tag = "R1";
      else if (mcnt != 0)             tag = "R6";
      else if (x_in_svc && y_in_svc)  tag = "R4";
      else if (msel == 0)             tag = "R5";
      else if (msel == 1)             tag = "R2";
      else                            tag = "R3";
      chk(wr_mask == em, {tag, " wr_mask"}, DW'(wr_mask), DW'(em));
      chk(stop_mask == ~em, "R7 stop_mask", DW'(stop_mask), DW'(~em));
      chk({y_rd, x_rd} == er, "R9 pops", DW'({y_rd, x_rd}), DW'(er));
      chk(out_valid == mov, "R8 out_valid", DW'(out_valid), DW'(mov));
      if (mov) chk(out_data == mod, "R8 out_data", out_data, mod);
   endtask

   task automatic step(input bit xs, input bit ys, input bit xv, input bit yv);
      seq++;
      x_in_svc = xs; y_in_svc = ys;
      x_valid  = xv; y_valid  = yv;
      x_data   = 32'hA000_0000 | DW'(seq);
      y_data   = 32'hB000_0000 | DW'(seq);
      #1;
      compare();
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) step(1, 0, 1, 1);            // R1 while held in reset
      rst_n = 1'b1;
      repeat (45) step(1, 0, 1, 1);           // R2 X only
      repeat (50) step(0, 1, 1, 1);           // R3/R6 switch requested mid packet
      for (int i = 0; i < 60; i++) step(1, 0, 1, (i % 3) != 0);   // R6 with gaps
      repeat (40) step(1, 1, 1, 1);           // R4 keep current
      repeat (40) step(0, 0, 1, 1);           // R5 idle
      repeat (30) step(1, 1, 1, 1);           // R4 from idle picks X
      for (int i = 0; i < 50; i++) step(0, 1, (i % 2) != 0, (i % 4) != 0);
      for (int i = 0; i < 50; i++) step(1, 0, (i % 5) != 0, 1);
      for (int i = 0; i < 30; i++) step((i % 7) < 3, (i % 7) >= 2, 1, (i % 2) != 0);
      repeat (30) step(0, 0, 1, 1);           // R5 idle after mixed traffic
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule